// File: doc/BRIEF.md
# Interrupt Distributor Global Control Block

This block is the small 32-bit register slave that holds the global control and identification words of an interrupt distributor. A request port carries valid, write, address and write data. Only address bits [3:2] pick the register inside a 16-byte window. The block holds one global enable bit. It reports a type word built from two elaboration parameters: the number of interrupt lines and the number of attached CPUs. It also reports a fixed identification word. Every accepted read returns its data one cycle later, with a response valid strobe.

The enable bit is kept by a two-state machine with the states `EN_OFF` and `EN_ON`. It has four transitions. `ARM` goes from `EN_OFF` to `EN_ON` on a control write with bit 0 set. `DISARM` goes from `EN_ON` to `EN_OFF` on a control write with bit 0 clear. `HOLD_OFF` and `HOLD_ON` cover every other cycle. The `ARM` transition alone raises a wake pulse one clock wide. The pulse is driven on every bit of a per-CPU wake vector, so that each CPU interface re-evaluates its pending interrupts.

Top module: `dist_ctrl_regs`

## Requirements
- R1: In the cycle after synchronous reset, `rsp_valid` and all bits of `cpu_wake` are 0. A read of the control word returns 0, because reset puts the state machine in `EN_OFF`.
- R2: Only `req_addr[3:2]` selects the register: 0 selects control, 1 selects type, 2 selects identification, and 3 reads as 0. All other address bits are ignored for both reads and writes.
- R3: Bit 0 of the control word is the global enable. A control read returns the last written bit 0 in bit 0 and 0 in bits [31:1].
- R4: The type word holds `NUM_LINES/32 - 1` in bits [4:0] and `NUM_CPUS - 1` in bits [7:5]. Bits [31:8] are 0. `NUM_LINES` counts the 32 private lines plus the shared lines.
- R5: The identification word holds `PRODUCT_CODE` (8 bits) in bits [31:24] and `IMPL_CODE` (12 bits) in bits [11:0]. Bits [23:12] are 0.
- R6: A write to select 1, 2 or 3 changes nothing. The enable bit keeps its value, no wake pulse is raised, and the type and identification words read back unchanged.
- R7: A control write that takes the enable from 0 to 1 (`ARM`) sets every bit of `cpu_wake` to 1 for exactly the one cycle after the accepting edge.
- R8: A control write that leaves the enable at 1, or that clears it (`DISARM`), raises no wake pulse.
- R9: For each accepted read, `rsp_valid` is 1 in the following cycle, with `rsp_rdata` holding the selected word as it was at the accepting edge. In all other cycles `rsp_valid` is 0 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request accepted at this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address; only bits [3:2] are decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| cpu_wake | output | NUM_CPUS | Wake pulse, one bit per CPU interface |

## Verification
Two results are due exactly one cycle after the edge that accepts a request: read data with its valid strobe, and the wake vector after a control write. A new enable value first appears in a read accepted on the edge after the write. The bench gives every request a due cycle equal to its issue cycle plus one. It pushes the full expected output picture for that cycle (valid, data, wake) into a scoreboard queue. A monitor pops each entry only in its due cycle, sampling mid-cycle, so an early, late or stretched pulse or response shows up as a mismatch. Idle cycles push entries of their own, so the cycle after a wake pulse is checked for silence.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_TYPE  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        EN_OFF = 1'b0,
        EN_ON  = 1'b1
    } en_state_e;

    typedef struct packed {
        logic     rd_req;
        logic     ctrl_wr;
        reg_sel_e sel;
    } req_dec_t;

endpackage

// File: rtl/dctl_decode.sv
module dctl_decode
    import dctl_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] word_sel,
    output req_dec_t   dec
);

    reg_sel_e sel;

    always_comb begin
        unique case (word_sel)
            2'd0:    sel = SEL_CTRL;
            2'd1:    sel = SEL_TYPE;
            2'd2:    sel = SEL_IDENT;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        dec.sel     = sel;
        dec.rd_req  = req_valid && !req_write;
        dec.ctrl_wr = req_valid && req_write && (sel == SEL_CTRL);
    end

endmodule

// File: rtl/dctl_enable_fsm.sv
module dctl_enable_fsm
    import dctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wr_bit,
    output logic en_on,
    output logic wake
);

    en_state_e state_q, state_d;
    logic      arm;

    // Transition selection: ARM, DISARM, HOLD_OFF, HOLD_ON
    always_comb begin
        state_d = state_q;
        arm     = 1'b0;
        unique case (state_q)
            EN_OFF: begin
                if (ctrl_wr && wr_bit) begin
                    state_d = EN_ON;   // ARM
                    arm     = 1'b1;
                end
            end
            EN_ON: begin
                if (ctrl_wr && !wr_bit) begin
                    state_d = EN_OFF;  // DISARM
                end
            end
            default: state_d = EN_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= EN_OFF;
        else     state_q <= state_d;
    end

    // Output register: wake is high only in the cycle after ARM
    always_ff @(posedge clk) begin
        if (rst) wake <= 1'b0;
        else     wake <= arm;
    end

    assign en_on = (state_q == EN_ON);

endmodule

// File: rtl/dctl_readmux.sv
module dctl_readmux
    import dctl_pkg::*;
#(
    parameter int NUM_LINES    = 96,
    parameter int NUM_CPUS     = 4,
    parameter int PRODUCT_CODE = 8'h4B,
    parameter int IMPL_CODE    = 12'h43B
) (
    input  logic              clk,
    input  logic              rst,
    input  req_dec_t          dec,
    input  logic              en_on,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [4:0] LINE_FIELD = 5'(NUM_LINES / 32 - 1);
    localparam logic [2:0] CPU_FIELD  = 3'(NUM_CPUS - 1);
    localparam logic [DATA_W-1:0] TYPE_WORD  = {24'd0, CPU_FIELD, LINE_FIELD};
    localparam logic [DATA_W-1:0] IDENT_WORD = {8'(PRODUCT_CODE), 12'd0, 12'(IMPL_CODE)};

    logic [DATA_W-1:0] word;

    always_comb begin
        unique case (dec.sel)
            SEL_CTRL:  word = {31'd0, en_on};
            SEL_TYPE:  word = TYPE_WORD;
            SEL_IDENT: word = IDENT_WORD;
            default:   word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= dec.rd_req;
            rsp_rdata <= dec.rd_req ? word : '0;
        end
    end

endmodule

// File: rtl/dist_ctrl_regs.sv
module dist_ctrl_regs
    import dctl_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int NUM_LINES    = 96,
    parameter int NUM_CPUS     = 4,
    parameter int PRODUCT_CODE = 8'h4B,
    parameter int IMPL_CODE    = 12'h43B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [NUM_CPUS-1:0] cpu_wake
);

    req_dec_t dec;
    logic     en_on;
    logic     wake;
    logic     unused_bits;

    assign unused_bits = ^{req_addr[ADDR_W-1:4], req_addr[1:0], req_wdata[31:1]};

    dctl_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .word_sel  (req_addr[3:2]),
        .dec       (dec)
    );

    dctl_enable_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (dec.ctrl_wr),
        .wr_bit  (req_wdata[0]),
        .en_on   (en_on),
        .wake    (wake)
    );

    dctl_readmux #(
        .NUM_LINES    (NUM_LINES),
        .NUM_CPUS     (NUM_CPUS),
        .PRODUCT_CODE (PRODUCT_CODE),
        .IMPL_CODE    (IMPL_CODE)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .en_on     (en_on),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_wake
        assign cpu_wake[c] = wake;
    end

endmodule

// File: rtl/dist_ctrl_regs_chk.sv
module dist_ctrl_regs_chk #(
    parameter int ADDR_W   = 12,
    parameter int NUM_CPUS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [31:0]         req_wdata,
    input logic                rsp_valid,
    input logic [31:0]         rsp_rdata,
    input logic [NUM_CPUS-1:0] cpu_wake,
    input logic                en_on
);

    logic ctl_wr;
    logic oth_wr;
    assign ctl_wr = req_valid && req_write && (req_addr[3:2] == 2'd0);
    assign oth_wr = req_valid && req_write && (req_addr[3:2] != 2'd0);

    AST_WAKE_ON_ARM: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && req_wdata[0] && !en_on) |=> (&cpu_wake)); // R7
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpu_wake[0] |=> !cpu_wake[0]); // R7
    AST_WAKE_ALL_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        (cpu_wake == '0) || (&cpu_wake)); // R7
    AST_NO_WAKE_WHEN_ON: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && en_on) |=> (cpu_wake == '0)); // R8
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        oth_wr |=> ($stable(en_on) && cpu_wake == '0)); // R6
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid); // R9
    AST_RSP_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_rdata == 32'd0)); // R9
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[3:2] == 2'd0) |=> (rsp_rdata[31:1] == 31'd0)); // R3

endmodule

bind dist_ctrl_regs dist_ctrl_regs_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_CPUS (NUM_CPUS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cpu_wake  (cpu_wake),
    .en_on     (en_on)
);

// File: tb/dist_ctrl_regs_tb.sv
module dist_ctrl_regs_tb;

    localparam int ADDR_W    = 12;
    localparam int NUM_LINES = 96;
    localparam int NUM_CPUS  = 4;
    localparam int PROD      = 8'h4B;
    localparam int IMPL      = 12'h43B;

    localparam logic [31:0] EXP_TYPE  = 32'((NUM_LINES / 32 - 1) + ((NUM_CPUS - 1) * 32));
    localparam logic [31:0] EXP_IDENT = 32'(PROD * (2 ** 24) + IMPL);
    localparam logic [NUM_CPUS-1:0] ALL_WAKE = '1;

    typedef struct {
        int                  due;
        logic                rv;
        logic [31:0]         rd;
        logic [NUM_CPUS-1:0] wk;
        string               tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NUM_CPUS-1:0] cpu_wake;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    bit   done     = 1'b0;
    logic model_en = 1'b0;
    exp_t sbq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dist_ctrl_regs #(
        .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS),
        .PRODUCT_CODE(PROD), .IMPL_CODE(IMPL)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .cpu_wake(cpu_wake)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] model_word(input logic [ADDR_W-1:0] a);
        case (a[3:2])
            2'd0:    return {31'd0, model_en};
            2'd1:    return EXP_TYPE;
            2'd2:    return EXP_IDENT;
            default: return 32'd0;
        endcase
    endfunction

    task automatic push(input logic rv, input logic [31:0] rd,
                        input logic [NUM_CPUS-1:0] wk, input string tag);
        exp_t e;
        e.due = cyc + 1; e.rv = rv; e.rd = rd; e.wk = wk; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        push(1'b0, 32'd0, '0, tag);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 32'hDEAD_BEEF;
        push(1'b1, model_word(a), '0, tag);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
        logic [NUM_CPUS-1:0] wk;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        wk = '0;
        if (a[3:2] == 2'd0) begin
            if (!model_en && d[0]) wk = ALL_WAKE;
            model_en = d[0];
        end
        push(1'b0, 32'd0, wk, tag);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sbq.size() != 0 && sbq[0].due == cyc) begin
                exp_t e;
                e = sbq.pop_front();
                check({e.tag, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, e.rv});
                check({e.tag, " rsp_rdata"}, rsp_rdata, e.rd);
                check({e.tag, " cpu_wake"}, 32'(cpu_wake), 32'(e.wk));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 cpu_wake in reset", 32'(cpu_wake), 32'd0);
        rst = 1'b0;
        do_read(12'h000, "R1 ctrl after reset");
        do_read(12'h004, "R4 type word");
        do_read(12'h014, "R2 type via high addr bits");
        do_read(12'h008, "R5 ident word");
        do_read(12'h00B, "R2 ident low addr bits ignored");
        do_read(12'h00C, "R2 reserved reads zero");
        do_read(12'hFFC, "R2 reserved high reads zero");
        do_write(12'h000, 32'h1, "R7 arm wake");
        do_idle("R7 wake one cycle");
        do_read(12'h000, "R3 enable readback");
        do_write(12'h000, 32'h1, "R8 rewrite while on");
        do_write(12'h000, 32'hFFFF_FFFF, "R8 all ones while on");
        do_read(12'h000, "R3 upper bits zero");
        do_write(12'h000, 32'h0, "R8 disarm no wake");
        do_read(12'h000, "R3 readback zero");
        do_write(12'h004, 32'h1, "R6 write type ignored");
        do_write(12'h008, 32'h1, "R6 write ident ignored");
        do_write(12'h00C, 32'h1, "R6 write reserved ignored");
        do_read(12'h000, "R6 enable unchanged");
        do_read(12'h004, "R6 type unchanged");
        do_read(12'h008, "R6 ident unchanged");
        do_write(12'h010, 32'h1, "R2 ctrl via high addr bits wake");
        do_read(12'h000, "R2 enable set via alias");
        do_write(12'h000, 32'hFFFF_FFFE, "R3 bit0 clear disables");
        do_write(12'h000, 32'h1, "R7 rearm back to back");
        do_read(12'h000, "R9 read right after write");
        do_idle("R9 no response when idle");
        do_write(12'h000, 32'h0, "R8 disarm again");
        do_idle("R8 quiet after disarm");
        rst = 1'b1;
        do_idle("R1 reset mid run");
        rst = 1'b0;
        model_en = 1'b0;
        sbq.delete();
        do_read(12'h000, "R1 ctrl cleared by reset");
        do_idle("R9 tail");
        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", 32'(sbq.size()), 32'd0);
        finish_run();
    end

endmodule